// File: doc/BRIEF.md
# Indexed Two-Source Vector Element Shuffle

The block builds a 128-bit result vector. Each result lane is an element chosen from a pool made of two 128-bit source vectors, `src_a` and `src_b`. A control element at the same lane position gives the index of the chosen element. The element width is picked at run time: 8, 16, 32 or 64 bits, which gives 16, 8, 4 or 2 lanes.

Only the low byte of each control element matters. Its two top bits force the lane to zero. Its low bits form an index into the pool, and the index wraps modulo twice the lane count. Index values below the lane count select from `src_b`. Higher values select from `src_a`.

In byte mode the control vector comes from its own operand, `ctl_vec`. In the wider modes the control vector is the old value of the destination register, `dst_old`. Every lane is computed from the operands as presented in the issuing cycle. The result is registered, and `out_valid` follows `in_valid` by one cycle. There is no backpressure.

Top module: `vec_idx_shuffle`

## Requirements
- R1: `elem_sz` selects the element width: 0 gives 8 bits (16 lanes), 1 gives 16 bits (8 lanes), 2 gives 32 bits (4 lanes) and 3 gives 64 bits (2 lanes). Lane i occupies bits [i*W +: W].
- R2: The index k of lane i is bits 5:0 of its control byte, taken modulo 2*m, where m is the lane count. In practice only bits 4:0, 3:0, 2:0 or 1:0 are used, for byte, halfword, word and doubleword widths.
- R3: When bit 7 or bit 6 of a lane's control byte is 1, that result lane is all zeros, whatever the index bits hold.
- R4: When k < m, the lane takes element k of `src_b`. Otherwise it takes element k-m of `src_a`.
- R5: The control byte of lane i is bits [i*W +: 8] of the control vector. The remaining bits of a wider control element have no effect.
- R6: When `elem_sz` is 0, the control vector is `ctl_vec` and `dst_old` has no effect. For any other width, the control vector is `dst_old` and `ctl_vec` has no effect.
- R7: All lanes are computed from the operand values of the issuing cycle. When `dst_old` carries the same value as a source, the result is the same as with separate copies.
- R8: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` at 1. `out_data` then holds the result for that issue.
- R9: While `in_valid` is 0, `out_data` keeps its value.
- R10: While `rst_n` is 0, `out_valid` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue strobe for the current operands |
| elem_sz | input | 2 | Element width select (0=8, 1=16, 2=32, 3=64 bits) |
| src_a | input | 128 | First source; supplies upper half of the pool |
| src_b | input | 128 | Second source; supplies lower half of the pool |
| ctl_vec | input | 128 | Control vector for byte width |
| dst_old | input | 128 | Old destination value; control vector for wider widths |
| out_valid | output | 1 | Result valid, one cycle after issue |
| out_data | output | 128 | Registered shuffle result |

## Verification
The identity-style byte controls, with indices 0..15 and then 16..31, show whether the two pool halves are assigned to the correct sources. Random operands at each of the four widths, checked against a model, test the lane placement and the index width per mode. Controls with only bit 6, only bit 7, or both set, combined with large index values and random upper control bits, separate zeroing, modulo wrap and low-byte extraction. Swapping the unused control operand, aliasing `dst_old` to a source, and idle cycles with changing inputs show which operand steers each mode, and that the result register holds.

// File: rtl/vsh_pkg.sv
package vsh_pkg;

  // Element width selector encoding
  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_H = 2'd1,
    ESZ_W = 2'd2,
    ESZ_D = 2'd3
  } esz_e;

  // Number of selectable element widths
  localparam int NUM_WIDTHS = 4;
  // Narrowest element width in bits
  localparam int MIN_EW = 8;
  // Position of the lower zeroing bit inside each control byte
  localparam int KILL_LSB = 6;
  // Number of zeroing bits inside each control byte
  localparam int KILL_BITS = 2;

endpackage

// File: rtl/vsh_ctrl_pick.sv
module vsh_ctrl_pick
  import vsh_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic [1:0]      elem_sz,
  input  logic [VLEN-1:0] ctl_vec,
  input  logic [VLEN-1:0] dst_old,
  output logic [VLEN-1:0] ctl_sel
);

  esz_e sz;

  assign sz = esz_e'(elem_sz);

  // Byte form uses the dedicated operand, wider forms reuse the destination
  always_comb begin
    if (sz == ESZ_B) begin
      ctl_sel = ctl_vec;
    end else begin
      ctl_sel = dst_old;
    end
  end

endmodule

// File: rtl/vsh_width_plane.sv
module vsh_width_plane
  import vsh_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int EW   = 8
) (
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  input  logic [VLEN-1:0] ctl,
  output logic [VLEN-1:0] res
);

  localparam int LANES = VLEN / EW;
  localparam int LIDX  = $clog2(LANES);
  localparam int IDX_W = LIDX + 1;

  logic [EW-1:0] elem_a [LANES];
  logic [EW-1:0] elem_b [LANES];
  logic          ctl_unused;

  // Only a few bits of each control byte are decoded at this width
  assign ctl_unused = ^ctl;

  for (genvar e = 0; e < LANES; e++) begin : g_elem
    assign elem_a[e] = src_a[e*EW +: EW];
    assign elem_b[e] = src_b[e*EW +: EW];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [IDX_W-1:0] idx;
    logic             kill;
    logic [EW-1:0]    pick;

    // Taking IDX_W low bits is the modulo-2m reduction (2m is a power of two)
    assign idx  = ctl[i*EW +: IDX_W];
    assign kill = |ctl[i*EW + KILL_LSB +: KILL_BITS];

    // Top index bit separates the upper pool half (src_a) from the lower (src_b)
    always_comb begin
      if (idx[IDX_W-1]) begin
        pick = elem_a[idx[LIDX-1:0]];
      end else begin
        pick = elem_b[idx[LIDX-1:0]];
      end
    end

    assign res[i*EW +: EW] = kill ? '0 : pick;
  end

endmodule

// File: rtl/vsh_out_reg.sv
module vsh_out_reg #(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [VLEN-1:0] in_data,
  output logic            out_valid,
  output logic [VLEN-1:0] out_data
);

  logic            valid_d;
  logic            valid_q;
  logic [VLEN-1:0] data_d;
  logic [VLEN-1:0] data_q;

  // Next-state: data loads only on an issue, valid mirrors the issue strobe
  always_comb begin
    valid_d = in_valid;
    data_d  = data_q;
    if (in_valid) begin
      data_d = in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  AST_VALID_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R8
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data)); // R9

endmodule

// File: rtl/vec_idx_shuffle.sv
module vec_idx_shuffle
  import vsh_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      elem_sz,
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  input  logic [VLEN-1:0] ctl_vec,
  input  logic [VLEN-1:0] dst_old,
  output logic            out_valid,
  output logic [VLEN-1:0] out_data
);

  localparam int BLANES = VLEN / MIN_EW;
  localparam int BIDX   = $clog2(BLANES);
  localparam int BOFS_W = $clog2(VLEN);

  logic [VLEN-1:0] ctl_sel;
  logic [VLEN-1:0] plane_res [NUM_WIDTHS];
  logic [VLEN-1:0] perm;
  esz_e            sz;

  assign sz = esz_e'(elem_sz);

  vsh_ctrl_pick #(.VLEN(VLEN)) u_ctrl (
    .elem_sz (elem_sz),
    .ctl_vec (ctl_vec),
    .dst_old (dst_old),
    .ctl_sel (ctl_sel)
  );

  // One permute plane per element width; the width select chooses among them
  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_plane
    vsh_width_plane #(.VLEN(VLEN), .EW(MIN_EW << g)) u_plane (
      .src_a (src_a),
      .src_b (src_b),
      .ctl   (ctl_sel),
      .res   (plane_res[g])
    );
  end

  always_comb begin
    case (sz)
      ESZ_B:   perm = plane_res[0];
      ESZ_H:   perm = plane_res[1];
      ESZ_W:   perm = plane_res[2];
      default: perm = plane_res[3];
    endcase
  end

  vsh_out_reg #(.VLEN(VLEN)) u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (perm),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // Port-level reference for byte lane 0, used only by the checks below
  logic [BOFS_W-1:0] chk_b0_ofs;
  logic [7:0]        chk_b0_ref;

  assign chk_b0_ofs = BOFS_W'({ctl_vec[BIDX-1:0], 3'b000});
  assign chk_b0_ref = ctl_vec[BIDX] ? src_a[chk_b0_ofs +: 8] : src_b[chk_b0_ofs +: 8];

  AST_BYTE_LANE0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sz == ESZ_B && ctl_vec[7:6] != 2'b00) |=> out_data[7:0] == 8'h00); // R3
  AST_BYTE_LANE0_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sz == ESZ_B && ctl_vec[7:6] == 2'b00) |=> out_data[7:0] == $past(chk_b0_ref)); // R4
  AST_DWORD_LANE0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sz == ESZ_D && dst_old[7:6] != 2'b00) |=> out_data[63:0] == 64'h0); // R6

endmodule

// File: tb/vec_idx_shuffle_tb.sv
module vec_idx_shuffle_tb;

  localparam int CLK_PERIOD = 10;
  localparam int VLEN       = 128;
  localparam int WATCHDOG   = 100000;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [1:0]      elem_sz;
  logic [VLEN-1:0] src_a;
  logic [VLEN-1:0] src_b;
  logic [VLEN-1:0] ctl_vec;
  logic [VLEN-1:0] dst_old;
  logic            out_valid;
  logic [VLEN-1:0] out_data;

  int checks;
  int failures;
  bit done;

  vec_idx_shuffle #(.VLEN(VLEN)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .elem_sz   (elem_sz),
    .src_a     (src_a),
    .src_b     (src_b),
    .ctl_vec   (ctl_vec),
    .dst_old   (dst_old),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [VLEN-1:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  // Random control: each byte has its zeroing bits cleared three times in four
  function automatic logic [VLEN-1:0] rnd_ctl();
    logic [VLEN-1:0] c;
    c = rnd128();
    for (int j = 0; j < VLEN / 8; j++) begin
      if (($urandom() % 4) != 0) c[j*8 + 6 +: 2] = 2'b00;
    end
    return c;
  endfunction

  // Model written from the requirements: pool split into src_b (low) and src_a (high)
  function automatic logic [VLEN-1:0] model(input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                                            input logic [VLEN-1:0] c, input logic [VLEN-1:0] d,
                                            input logic [1:0] sz);
    logic [VLEN-1:0] r;
    logic [VLEN-1:0] ctl;
    logic [7:0]      cb;
    int ew;
    int m;
    int k;
    r   = '0;
    ew  = 8 << sz;
    m   = VLEN / ew;
    ctl = (sz == 2'd0) ? c : d;
    for (int i = 0; i < m; i++) begin
      cb = ctl[i*ew +: 8];
      k  = int'(cb[5:0]) % (2 * m);
      if (cb[7] == 1'b0 && cb[6] == 1'b0) begin
        for (int j = 0; j < ew; j++) begin
          r[i*ew + j] = (k < m) ? b[k*ew + j] : a[(k - m)*ew + j];
        end
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Issue one operation; sample the registered result on the following falling edge
  task automatic issue(input logic [1:0] sz, input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                       input logic [VLEN-1:0] c, input logic [VLEN-1:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    elem_sz  = sz;
    src_a    = a;
    src_b    = b;
    ctl_vec  = c;
    dst_old  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n    = 1'b0;
    in_valid = 1'b0;
    elem_sz  = 2'd0;
    src_a    = '1;
    src_b    = '1;
    ctl_vec  = '0;
    dst_old  = '0;
    repeat (3) @(negedge clk);
    chk1("R10 out_valid in reset", out_valid, 1'b0);
    chk("R10 out_data in reset", out_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk1("R8 no valid without issue", out_valid, 1'b0);
  endtask

  task automatic t_identity_byte();
    logic [VLEN-1:0] a;
    logic [VLEN-1:0] b;
    logic [VLEN-1:0] c;
    a = rnd128();
    b = rnd128();
    for (int i = 0; i < 16; i++) c[i*8 +: 8] = 8'(i);
    issue(2'd0, a, b, c, rnd128());
    chk1("R8 valid after issue", out_valid, 1'b1);
    chk("R4 indices 0..15 give src_b", out_data, b);
    for (int i = 0; i < 16; i++) c[i*8 +: 8] = 8'(16 + i);
    issue(2'd0, a, b, c, rnd128());
    chk("R4 indices 16..31 give src_a", out_data, a);
  endtask

  task automatic t_random_widths();
    logic [VLEN-1:0] a;
    logic [VLEN-1:0] b;
    logic [VLEN-1:0] c;
    logic [VLEN-1:0] d;
    for (int s = 0; s < 4; s++) begin
      for (int n = 0; n < 25; n++) begin
        a = rnd128();
        b = rnd128();
        c = rnd_ctl();
        d = rnd_ctl();
        issue(2'(s), a, b, c, d);
        chk($sformatf("R1 R2 R4 random width sel %0d", s), out_data, model(a, b, c, d, 2'(s)));
      end
    end
  endtask

  task automatic t_zeroing();
    logic [VLEN-1:0] a;
    logic [VLEN-1:0] b;
    logic [VLEN-1:0] c;
    logic [VLEN-1:0] exp;
    a = rnd128();
    b = rnd128();
    exp = '0;
    // Lane i: i%4 == 0 -> bit 6 only, 1 -> bit 7 only, 2 -> both, 3 -> clear, index 5
    for (int i = 0; i < 16; i++) begin
      case (i % 4)
        0:       c[i*8 +: 8] = 8'h45;
        1:       c[i*8 +: 8] = 8'h85;
        2:       c[i*8 +: 8] = 8'hC5;
        default: c[i*8 +: 8] = 8'h05;
      endcase
      if (i % 4 == 3) exp[i*8 +: 8] = b[5*8 +: 8];
    end
    issue(2'd0, a, b, c, '0);
    chk("R3 byte lanes with bit 6 or 7 zeroed", out_data, exp);
    // Halfword: the low byte of lane 0 carries bit 7; lane 1 has bit 7 set only above the low byte
    c = '0;
    c[7:0]   = 8'h81;
    c[23:16] = 8'h02;
    c[31:24] = 8'h80;
    exp = model(a, b, '0, c, 2'd1);
    issue(2'd1, a, b, '0, c);
    chk("R3 halfword lane0 zeroed", {112'h0, out_data[15:0]}, 128'h0);
    chk("R5 halfword lane1 high control byte ignored", {112'h0, out_data[31:16]}, {112'h0, b[47:32]});
    chk("R3 halfword full", out_data, exp);
  endtask

  task automatic t_wrap();
    logic [VLEN-1:0] a;
    logic [VLEN-1:0] b;
    logic [VLEN-1:0] d;
    a = rnd128();
    b = rnd128();
    // Halfword, control 0x2F: 47 mod 16 = 15 -> src_a element 7
    d = '0;
    d[7:0] = 8'h2F;
    issue(2'd1, a, b, '0, d);
    chk("R2 halfword wrap 0x2F", {112'h0, out_data[15:0]}, {112'h0, a[127:112]});
    // Doubleword, control 0x3E: 62 mod 4 = 2 -> src_a element 0; lane 1 control 0x25 -> 1 -> src_b element 1
    d = '0;
    d[7:0]   = 8'h3E;
    d[71:64] = 8'h25;
    issue(2'd3, a, b, '0, d);
    chk("R2 doubleword wrap", out_data, {b[127:64], a[63:0]});
    // Byte, control 0x3F: 63 mod 32 = 31 -> src_a element 15
    d = '0;
    d[7:0] = 8'h3F;
    issue(2'd0, a, b, d, '0);
    chk("R2 byte wrap 0x3F", {120'h0, out_data[7:0]}, {120'h0, a[127:120]});
  endtask

  task automatic t_upper_bits();
    logic [VLEN-1:0] a;
    logic [VLEN-1:0] b;
    logic [VLEN-1:0] d;
    logic [VLEN-1:0] d2;
    a = rnd128();
    b = rnd128();
    d = '0;
    for (int i = 0; i < 4; i++) d[i*32 +: 8] = 8'(3 - i);
    d2 = rnd128();
    for (int i = 0; i < 4; i++) d2[i*32 +: 8] = d[i*32 +: 8];
    issue(2'd2, a, b, '0, d2);
    chk("R5 word upper control bits ignored", out_data, {b[31:0], b[63:32], b[95:64], b[127:96]});
  endtask

  task automatic t_ctrl_source();
    logic [VLEN-1:0] a;
    logic [VLEN-1:0] b;
    logic [VLEN-1:0] c;
    logic [VLEN-1:0] d;
    logic [VLEN-1:0] exp;
    a = rnd128();
    b = rnd128();
    c = rnd_ctl();
    d = rnd_ctl();
    exp = model(a, b, c, '0, 2'd0);
    issue(2'd0, a, b, c, d);
    chk("R6 byte uses ctl_vec", out_data, exp);
    issue(2'd0, a, b, c, ~d);
    chk("R6 byte ignores dst_old", out_data, exp);
    exp = model(a, b, '0, d, 2'd2);
    issue(2'd2, a, b, c, d);
    chk("R6 word uses dst_old", out_data, exp);
    issue(2'd2, a, b, ~c, d);
    chk("R6 word ignores ctl_vec", out_data, exp);
  endtask

  task automatic t_overlap();
    logic [VLEN-1:0] a;
    logic [VLEN-1:0] b;
    a = rnd_ctl();
    b = rnd128();
    issue(2'd2, a, b, '0, a);
    chk("R7 dst_old aliased to src_a", out_data, model(a, b, '0, a, 2'd2));
    issue(2'd3, b, b, '0, b);
    chk("R7 dst_old aliased to both sources", out_data, model(b, b, '0, b, 2'd3));
  endtask

  task automatic t_hold();
    logic [VLEN-1:0] a;
    logic [VLEN-1:0] b;
    logic [VLEN-1:0] c;
    logic [VLEN-1:0] exp;
    a = rnd128();
    b = rnd128();
    c = rnd_ctl();
    exp = model(a, b, c, '0, 2'd0);
    issue(2'd0, a, b, c, '0);
    chk("R8 result one cycle after issue", out_data, exp);
    src_a   = rnd128();
    src_b   = rnd128();
    ctl_vec = rnd128();
    elem_sz = 2'd3;
    @(negedge clk);
    chk1("R8 valid for one cycle only", out_valid, 1'b0);
    chk("R9 result held while idle", out_data, exp);
    src_a = rnd128();
    @(negedge clk);
    chk("R9 result held second idle cycle", out_data, exp);
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    done     = 1'b0;
    t_reset();
    t_identity_byte();
    t_random_widths();
    t_zeroing();
    t_wrap();
    t_upper_bits();
    t_ctrl_source();
    t_overlap();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule